// File: doc/BRIEF.md
# Quad-Channel Serial DAC Write Controller

This block drives a four-channel, 16-bit digital-to-analog converter over a write-only serial link. After reset the block is inactive. A one-cycle pulse on `bring_up` starts a one-time power-on sequence on the enable, frame-select and load lines. Once that sequence has finished, the block is armed. From then on, each accepted request becomes a 24-bit serial frame: a command byte that selects one channel or all channels, followed by the 16-bit code, most significant bit first.

Requests arrive on a valid/ready stream. A transfer takes place on a rising clock edge where `req_valid` and `req_ready` are both high. `req_ready` is low while the power-on sequence runs and while a frame is on the wire. The source must hold `req_valid` and its payload stable until the transfer takes place, and the block takes at most one request per frame. Before the block is armed, `req_ready` is high. Requests are then taken and thrown away, with no activity on the serial pins and no error. The serial clock is the system clock divided by the even parameter `CLK_DIV`. It idles high, and MOSI changes on its falling edge.

Top module: `qdac_spi_writer`

## Requirements
- R1: After synchronous reset: `dac_en`=1, `fsel_n`=1, `load`=0, `sclk`=1, `armed`=0, `err_flag`=0 and `req_ready`=1.
- R2: While `armed`=0 and no power-on sequence is running, a request is accepted and dropped. `fsel_n` and `dac_en` stay high, no frame is sent and `err_flag` is unchanged.
- R3: A `bring_up` pulse seen while inactive starts the power-on sequence, one system clock cycle per step: `dac_en` low; `fsel_n` low; `fsel_n` high; `dac_en` high. After that, `load` stays low for WAIT_CYC cycles, then high for WAIT_CYC cycles, then returns low and `armed` rises. Once `armed` is set it stays set with `load` low, and `req_ready` is low throughout the sequence.
- R4: Frame content is 24 bits sent MSB first: command byte, then code[15:8], then code[7:0]. The command byte is 0x10 ORed with 2×`req_chan[1:0]` (A=0x10, B=0x12, C=0x14, D=0x16). When `req_all`=1 the command byte is 0x17 and `req_chan` is ignored.
- R5: `sclk` is high whenever `fsel_n` is high. During a frame, `fsel_n` stays low for exactly 24×CLK_DIV system cycles and contains exactly 24 rising `sclk` edges. MOSI changes only in the cycle where `sclk` falls.
- R6: `dac_en` is low whenever `fsel_n` is low. In a write, `dac_en` falls one cycle before `fsel_n` and rises one cycle after it.
- R7: After an armed, legal request is accepted, `req_ready` is low from the next cycle until the frame ends. While `req_ready` is high, `fsel_n` and `dac_en` are both high.
- R8: When armed, a request with `req_all`=0 and `req_chan` of 4 to 7 is illegal. It is accepted, sends no frame and sets `err_flag`, which stays set until reset.
- R9: A `bring_up` pulse while armed has no effect: `load` stays low and `dac_en` stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bring_up | input | 1 | Pulse to start the power-on sequence |
| req_valid | input | 1 | Request valid |
| req_ready | output | 1 | Request ready |
| req_chan | input | 3 | Channel index (0..3 legal) |
| req_all | input | 1 | Write all channels |
| req_code | input | 16 | Code to convert |
| sclk | output | 1 | Serial clock, idles high |
| mosi | output | 1 | Serial data out |
| fsel_n | output | 1 | Frame select, active low |
| dac_en | output | 1 | Converter enable line, low while the converter is addressed |
| load | output | 1 | Load strobe line |
| armed | output | 1 | Power-on sequence complete |
| err_flag | output | 1 | Sticky illegal-channel flag |

## Verification
The assertions check the following on every cycle:
- the line relationships: enable low under frame select, clock high outside a frame, MOSI still except at a falling clock edge;
- back-pressure after an accepted request;
- silence on the bus for dropped requests;
- that the armed and error flags stay set.

Only the bench scenarios show the rest:
- the frame contents;
- the exact power-on step order and WAIT_CYC durations;
- the count of 24×CLK_DIV cycles per frame;
- that a repeated `bring_up` does nothing.

// File: rtl/qdac_pkg.sv
package qdac_pkg;
  localparam int FRAME_BITS = 24;
  localparam int CODE_BITS  = 16;
  localparam logic [7:0] CMD_PREFIX = 8'h10;
  localparam logic [7:0] CMD_ALL    = 8'h07;

  typedef enum logic [2:0] {
    BU_OFF, BU_EN_LO, BU_FS_LO, BU_FS_HI, BU_EN_HI, BU_LD_LO, BU_LD_HI, BU_ON
  } bu_state_t;

  typedef enum logic [1:0] {TX_IDLE, TX_LEAD, TX_SHIFT, TX_TRAIL} tx_state_t;

  function automatic logic [7:0] cmd_byte(input logic all, input logic [1:0] idx);
    if (all) return CMD_PREFIX | CMD_ALL;
    return CMD_PREFIX | {5'b0, idx, 1'b0};
  endfunction
endpackage

// File: rtl/qdac_bringup.sv
module qdac_bringup
  import qdac_pkg::*;
#(
  parameter int WAIT_CYC = 10000
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic armed,
  output logic en_line,
  output logic fs_line_n,
  output logic load_line
);
  localparam int CW = $clog2(WAIT_CYC + 1);

  bu_state_t      st;
  logic [CW-1:0]  wcnt;
  logic           wdone;

  assign wdone = (wcnt == CW'(WAIT_CYC - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= BU_OFF;
      wcnt <= '0;
    end else begin
      case (st)
        BU_OFF:   if (start) st <= BU_EN_LO;
        BU_EN_LO: st <= BU_FS_LO;
        BU_FS_LO: st <= BU_FS_HI;
        BU_FS_HI: st <= BU_EN_HI;
        BU_EN_HI: begin
          st   <= BU_LD_LO;
          wcnt <= '0;
        end
        BU_LD_LO: begin
          if (wdone) begin
            st   <= BU_LD_HI;
            wcnt <= '0;
          end else begin
            wcnt <= wcnt + 1'b1;
          end
        end
        BU_LD_HI: begin
          if (wdone) st <= BU_ON;
          else       wcnt <= wcnt + 1'b1;
        end
        default:  st <= BU_ON;
      endcase
    end
  end

  assign busy      = (st != BU_OFF) && (st != BU_ON);
  assign armed     = (st == BU_ON);
  assign en_line   = !((st == BU_EN_LO) || (st == BU_FS_LO) || (st == BU_FS_HI));
  assign fs_line_n = (st != BU_FS_LO);
  assign load_line = (st == BU_LD_HI);
endmodule

// File: rtl/qdac_frame_fmt.sv
module qdac_frame_fmt
  import qdac_pkg::*;
(
  input  logic                  all,
  input  logic [2:0]            idx,
  input  logic [CODE_BITS-1:0]  code,
  output logic [FRAME_BITS-1:0] frame,
  output logic                  illegal
);
  localparam int NBYTES = FRAME_BITS / 8;

  logic [7:0] bytes [NBYTES];

  assign bytes[0] = cmd_byte(all, idx[1:0]);

  for (genvar b = 1; b < NBYTES; b++) begin : g_code_bytes
    assign bytes[b] = code[CODE_BITS-1-8*(b-1) -: 8];
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_pack
    assign frame[FRAME_BITS-1-8*b -: 8] = bytes[b];
  end

  assign illegal = !all && idx[2];
endmodule

// File: rtl/qdac_shifter.sv
module qdac_shifter
  import qdac_pkg::*;
#(
  parameter int CLK_DIV = 4
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  start,
  input  logic [FRAME_BITS-1:0] frame,
  output logic                  busy,
  output logic                  en_low,
  output logic                  fs_n,
  output logic                  sclk,
  output logic                  mosi
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CCW  = (CLK_DIV > 2) ? $clog2(CLK_DIV) : 1;
  localparam int BW   = $clog2(FRAME_BITS);

  tx_state_t             st;
  logic [CCW-1:0]        cyc;
  logic [BW-1:0]         bitn;
  logic [FRAME_BITS-1:0] sreg;

  always_ff @(posedge clk) begin
    if (rst) begin
      st   <= TX_IDLE;
      cyc  <= '0;
      bitn <= '0;
      sreg <= '0;
    end else begin
      case (st)
        TX_IDLE: if (start) begin
          sreg <= frame;
          st   <= TX_LEAD;
        end
        TX_LEAD: begin
          st   <= TX_SHIFT;
          cyc  <= '0;
          bitn <= '0;
        end
        TX_SHIFT: begin
          if (cyc == CCW'(CLK_DIV - 1)) begin
            cyc  <= '0;
            sreg <= {sreg[FRAME_BITS-2:0], 1'b0};
            if (bitn == BW'(FRAME_BITS - 1)) st <= TX_TRAIL;
            else                              bitn <= bitn + 1'b1;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: st <= TX_IDLE;
      endcase
    end
  end

  assign busy   = (st != TX_IDLE);
  assign en_low = (st != TX_IDLE);
  assign fs_n   = (st != TX_SHIFT);
  assign sclk   = !((st == TX_SHIFT) && (cyc < CCW'(HALF)));
  assign mosi   = (st == TX_SHIFT) ? sreg[FRAME_BITS-1] : 1'b0;
endmodule

// File: rtl/qdac_spi_writer.sv
module qdac_spi_writer
  import qdac_pkg::*;
#(
  parameter int CLK_DIV  = 4,
  parameter int WAIT_CYC = 10000
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        bring_up,
  input  logic        req_valid,
  output logic        req_ready,
  input  logic [2:0]  req_chan,
  input  logic        req_all,
  input  logic [15:0] req_code,
  output logic        sclk,
  output logic        mosi,
  output logic        fsel_n,
  output logic        dac_en,
  output logic        load,
  output logic        armed,
  output logic        err_flag
);
  logic                  bu_busy, bu_en, bu_fs_n, bu_load, bu_armed;
  logic                  tx_busy, tx_en_low, tx_fs_n, tx_sclk, tx_mosi;
  logic [FRAME_BITS-1:0] frame;
  logic                  illegal, accept, tx_start;

  qdac_bringup #(.WAIT_CYC(WAIT_CYC)) u_bu (
    .clk(clk), .rst(rst), .start(bring_up),
    .busy(bu_busy), .armed(bu_armed), .en_line(bu_en),
    .fs_line_n(bu_fs_n), .load_line(bu_load)
  );

  qdac_frame_fmt u_fmt (
    .all(req_all), .idx(req_chan), .code(req_code),
    .frame(frame), .illegal(illegal)
  );

  qdac_shifter #(.CLK_DIV(CLK_DIV)) u_tx (
    .clk(clk), .rst(rst), .start(tx_start), .frame(frame),
    .busy(tx_busy), .en_low(tx_en_low), .fs_n(tx_fs_n),
    .sclk(tx_sclk), .mosi(tx_mosi)
  );

  assign req_ready = !bu_busy && !tx_busy;
  assign accept    = req_valid && req_ready;
  assign tx_start  = accept && bu_armed && !illegal;

  always_ff @(posedge clk) begin
    if (rst)                                err_flag <= 1'b0;
    else if (accept && bu_armed && illegal) err_flag <= 1'b1;
  end

  assign armed  = bu_armed;
  assign load   = bu_load;
  assign dac_en = bu_en && !tx_en_low;
  assign fsel_n = bu_fs_n && tx_fs_n;
  assign sclk   = tx_sclk;
  assign mosi   = tx_mosi;
endmodule

// File: rtl/qdac_spi_writer_chk.sv
module qdac_spi_writer_chk (
  input logic       clk,
  input logic       rst,
  input logic       bring_up,
  input logic       req_valid,
  input logic       req_ready,
  input logic [2:0] req_chan,
  input logic       req_all,
  input logic       sclk,
  input logic       mosi,
  input logic       fsel_n,
  input logic       dac_en,
  input logic       load,
  input logic       armed,
  input logic       err_flag
);
  AST_ARMED_STICKY: assert property (@(posedge clk) disable iff (rst)
    armed |=> armed); // R3
  AST_LOAD_LOW_ARMED: assert property (@(posedge clk) disable iff (rst)
    armed |-> !load); // R3
  AST_SCLK_IDLE_HIGH: assert property (@(posedge clk) disable iff (rst)
    fsel_n |-> sclk); // R5
  AST_MOSI_ON_FALL: assert property (@(posedge clk) disable iff (rst)
    (!fsel_n && $past(!fsel_n) && !$fell(sclk)) |-> $stable(mosi)); // R5
  AST_EN_UNDER_FS: assert property (@(posedge clk) disable iff (rst)
    !fsel_n |-> !dac_en); // R6
  AST_BUSY_AFTER_ACCEPT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && armed && (req_all || !req_chan[2])) |=> !req_ready); // R7
  AST_IDLE_LINES: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (fsel_n && dac_en)); // R7
  AST_DROP_SILENT: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !armed && !bring_up) |=> (fsel_n && dac_en && req_ready)); // R2
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_flag |=> err_flag); // R8
endmodule

bind qdac_spi_writer qdac_spi_writer_chk u_chk (.*);

// File: tb/qdac_spi_writer_test.sv
module qdac_spi_writer_test;
  localparam int DIV = 4;
  localparam int W   = 16;

  logic clk = 1'b0, rst = 1'b1, bring_up = 1'b0, req_valid = 1'b0, req_all = 1'b0;
  logic [2:0] req_chan = '0;
  logic [15:0] req_code = '0;
  logic req_ready, sclk, mosi, fsel_n, dac_en, load, armed, err_flag;

  int checks = 0, fails = 0;
  bit done = 0;

  qdac_spi_writer #(.CLK_DIV(DIV), .WAIT_CYC(W)) uut (.*);

  always #2.5 clk = ~clk;

  // serial monitor
  logic [23:0] rx = '0, last_rx = '0;
  int rxcnt = 0, last_cnt = 0, frames = 0, lowcnt = 0, last_low = 0, en_low_cnt = 0;

  always @(posedge sclk) if (!fsel_n) begin rx = {rx[22:0], mosi}; rxcnt++; end
  always @(negedge fsel_n) rxcnt = 0;
  always @(posedge fsel_n) if (rxcnt > 0) begin last_rx = rx; last_cnt = rxcnt; frames++; end
  always @(posedge clk) begin
    if (!dac_en) en_low_cnt++;
    if (!fsel_n) lowcnt++;
    else if (lowcnt != 0) begin last_low = lowcnt; lowcnt = 0; end
  end

  function automatic logic [23:0] exp_frame(input logic all, input logic [2:0] idx, input logic [15:0] v);
    logic [7:0] c;
    c = all ? 8'h17 : (8'h10 | {5'b0, idx[1:0], 1'b0});
    return {c, v};
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send(input logic all, input logic [2:0] idx, input logic [15:0] v);
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    req_valid = 1'b1; req_all = all; req_chan = idx; req_code = v;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    while (!req_ready) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic legal_frame(input logic all, input logic [2:0] idx, input logic [15:0] v, input string req);
    int f0;
    f0 = frames;
    send(all, idx, v);
    chk(frames == f0 + 1, req, frames, f0 + 1);
    chk(last_rx == exp_frame(all, idx, v), req, last_rx, exp_frame(all, idx, v));
    chk(last_cnt == 24 && last_low == 24 * DIV, "R5", last_low, 24 * DIV);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    int f0, e0, bad;
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(dac_en && fsel_n && !load && sclk && !armed && !err_flag && req_ready, "R1",
        {dac_en, fsel_n, load, sclk, armed, err_flag, req_ready}, 7'b1101001);

    // R2 drop before arming (illegal index too: no error)
    f0 = frames; e0 = en_low_cnt;
    send(1'b0, 3'd1, 16'hBEEF);
    send(1'b0, 3'd6, 16'h1234);
    chk(frames == f0 && en_low_cnt == e0 && fsel_n, "R2", frames - f0, 0);
    chk(!err_flag, "R2", err_flag, 0);

    // R3 power-on sequence
    @(negedge clk) bring_up = 1'b1;
    @(negedge clk) bring_up = 1'b0;
    chk(!dac_en && fsel_n && !load && !req_ready, "R3", {dac_en, fsel_n, load}, 3'b010);
    @(negedge clk);
    chk(!dac_en && !fsel_n && !load, "R3", {dac_en, fsel_n, load}, 3'b000);
    @(negedge clk);
    chk(!dac_en && fsel_n && !load, "R3", {dac_en, fsel_n, load}, 3'b010);
    @(negedge clk);
    chk(dac_en && fsel_n && !load, "R3", {dac_en, fsel_n, load}, 3'b110);
    bad = 0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (load || armed || req_ready) bad++;
    end
    chk(bad == 0, "R3", bad, 0);
    bad = 0;
    for (int i = 0; i < W; i++) begin
      @(negedge clk);
      if (!load || armed || req_ready) bad++;
    end
    chk(bad == 0, "R3", bad, 0);
    @(negedge clk);
    chk(armed && !load && req_ready, "R3", {armed, load, req_ready}, 3'b101);

    // R4 directed channels
    legal_frame(1'b0, 3'd0, 16'h0000, "R4");
    legal_frame(1'b0, 3'd1, 16'hFFFF, "R4");
    legal_frame(1'b0, 3'd2, 16'hA55A, "R4");
    legal_frame(1'b0, 3'd3, 16'h8001, "R4");
    legal_frame(1'b1, 3'd5, 16'h1357, "R4");

    // R8 illegal index
    chk(!err_flag, "R8", err_flag, 0);
    f0 = frames;
    send(1'b0, 3'd4, 16'h7777);
    chk(frames == f0 && err_flag, "R8", {frames - f0, err_flag}, 1);

    // R9 bring_up while armed
    e0 = en_low_cnt; bad = 0;
    @(negedge clk) bring_up = 1'b1;
    @(negedge clk) bring_up = 1'b0;
    for (int i = 0; i < 2 * W + 8; i++) begin
      @(negedge clk);
      if (load || !dac_en || !armed) bad++;
    end
    chk(bad == 0 && en_low_cnt == e0, "R9", bad, 0);

    // random mix (R4, R5, R8)
    for (int n = 0; n < 40; n++) begin
      logic [31:0] r;
      logic all;
      logic [2:0] idx;
      logic [15:0] v;
      r = $urandom;
      all = (r[2:0] == 3'd0);
      idx = (r[6:4] == 3'd1) ? {1'b1, r[9:8]} : {1'b0, r[13:12]};
      v = 16'($urandom);
      if (!all && idx[2]) begin
        f0 = frames;
        send(all, idx, v);
        chk(frames == f0 && err_flag, "R8", frames - f0, 0);
      end else begin
        legal_frame(all, idx, v, "R4");
      end
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule